// File: doc/BRIEF.md
# ARINC 429 Byte-Loaded Serial Transmitter

This block turns four writes of an 8-bit parallel bus into one 32-bit ARINC 429 word and sends it serially, one bit per bit-clock period, with the inter-word gap inserted automatically. A byte written with `label_wr` high is the label. It starts a new word. The next three writes, made with `label_wr` low, complete the word. A holding buffer takes the finished word while the previous word is still going out, so a host can keep the line busy with back-to-back words.

The bit clock is derived from the system clock. Each bit period lasts `CLKS_PER_BIT` clock cycles. Its first half is the high phase of `bit_clk` and its second half is the low phase. The line is reported in two forms. The first is a pair of return-to-zero one/zero indicators, as used to steer a 429 line driver. The second is an NRZ data line with an active-low sync strobe, as used by the older 561 style of link. Bit 32 can be sent either as an odd-parity bit or as data.

Top module: `arinc_byte_tx`

## Requirements
- R1: A write with `label_wr` high loads byte 1 and restarts assembly. Writes with `label_wr` low load bytes 2, 3 and 4 in turn. A low-address write made when no label has been written since the last completed word is ignored.
- R2: Byte n fills serial bits 8n-7 to 8n. Bus bit 0 of each byte goes to the lowest-numbered serial bit of that byte, and serial bit 1 is transmitted first.
- R3: A bit period lasts `CLKS_PER_BIT` clock cycles. Every word is followed by at least 4 null bit periods, and a word already waiting in the buffer starts after exactly 4, which gives a 36-bit slot.
- R4: With `par_en` high when the word moves to the shifter, serial bit 32 is set so that the 32 transmitted bits hold an odd number of ones. With `par_en` low, bit 32 is bus bit 7 of byte 4.
- R5: `ready` is high while the holding buffer is empty. It goes low in the cycle after the fourth byte is captured and goes high again when the buffer contents move into the shift register.
- R6: A waiting word moves into the shifter at the start of the fourth gap bit of the word being sent. When that point has already passed, or the line is idle, the move happens at the next bit-period boundary after the fourth byte, and transmission starts in that bit period.
- R7: Synchronous active-high `rst` clears all state. After reset `ready` is high, both indicators are low, `ser_sync_n` is high, and the line stays null until a complete word has been loaded.
- R8: `line_one` is high for a transmitted 1 and `line_zero` for a transmitted 0, only during the high half of `bit_clk`. Both are low in gap and idle periods and are never high together.
- R9: `ser_data` equals the bit being sent for the whole of each data bit period and is low during gap and idle periods.
- R10: `ser_sync_n` is low during the low half of serial bit 8 of each word, and high at every other time.
- R11: A byte is captured on the sampled rising edge of `wr_n` that follows at least one sampled low. A write made while `ready` is low has no effect on the buffered word.
- R12: A `label_wr`-high write made partway through a word discards the bytes written so far, and assembly restarts with this byte as byte 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Parallel byte bus |
| label_wr | input | 1 | High: this write is the label (byte 1); low: bytes 2 to 4 |
| wr_n | input | 1 | Write strobe, active low; the byte is taken on its rising edge |
| par_en | input | 1 | High: bit 32 carries odd parity |
| ready | output | 1 | Holding buffer empty, bytes may be written |
| line_one | output | 1 | Return-to-zero marker for a transmitted 1 |
| line_zero | output | 1 | Return-to-zero marker for a transmitted 0 |
| ser_data | output | 1 | NRZ serial data |
| ser_sync_n | output | 1 | Active-low strobe in the low half of bit 8 |
| bit_clk | output | 1 | Bit clock, high for the first half of each bit period |

## Verification
The assertions check, on every cycle, the properties that hold regardless of which word is sent. The indicators are exclusive and appear only in the high half of `bit_clk`. The sync strobe appears only in the low half. Gap periods stay null. A full buffer holds its word against further writes. A transfer happens only at an idle boundary or in the last gap bits, and is followed at once by bit 1. A label write restarts the byte count, and an orphan low write changes nothing. Only the bench scenarios can show the properties that depend on content and history: that the received words match the bytes written, the parity value, the exact 4-bit gap between back-to-back words, when `ready` falls and rises, that the sync strobe falls on bit 8, and that ignored or discarded writes leave no trace in what is sent.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
  localparam int BYTE_W         = 8;
  localparam int BYTES_PER_WORD = 4;
  localparam int WORD_W         = BYTE_W * BYTES_PER_WORD;
  localparam int GAP_BITS       = 4;
  localparam int SLOT_BITS      = WORD_W + GAP_BITS;
  localparam int SYNC_BIT       = 8;  // 1-based serial position of the sync strobe

  // Apply the bit-32 policy to an assembled word.
  function automatic logic [WORD_W-1:0] seal_word(input logic [WORD_W-1:0] w,
                                                  input logic            par_en);
    logic [WORD_W-1:0] r;
    r = w;
    if (par_en) r[WORD_W-1] = ~^w[WORD_W-2:0];
    return r;
  endfunction
endpackage

// File: rtl/arinc_bit_timer.sv
module arinc_bit_timer #(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst,
  output logic bit_end_o,
  output logic high_o
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst)                cyc_q <= '0;
    else if (cyc_q == LAST) cyc_q <= '0;
    else                    cyc_q <= cyc_q + CW'(1);
  end

  assign bit_end_o = (cyc_q == LAST);
  assign high_o    = (cyc_q < HALF);
endmodule

// File: rtl/arinc_byte_loader.sv
module arinc_byte_loader
  import arinc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] bus_i,
  input  logic              label_i,
  input  logic              wr_n_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(BYTES_PER_WORD);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTES_PER_WORD - 1);

  logic             wr_n_q;
  logic             full_q;
  logic [CNT_W-1:0] cnt_q;
  logic             strobe, cap, cap_label, cap_body;
  logic [BYTES_PER_WORD-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n_i;
  end

  assign strobe    = !wr_n_q && wr_n_i;
  assign cap       = strobe && !full_q;
  assign cap_label = cap && label_i;
  assign cap_body  = cap && !label_i && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (cap_label) begin
      cnt_q <= CNT_W'(1);
    end else if (cap_body) begin
      if (cnt_q == LAST_BYTE) begin
        full_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    assign sel[g] = (g == 0) ? cap_label : (cap_body && (cnt_q == CNT_W'(g)));
    always_ff @(posedge clk) begin
      if (rst)         byte_q <= '0;
      else if (sel[g]) byte_q <= bus_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = byte_q;
  end

  assign full_o = full_q;

  // R5: a full buffer stays full until the shifter takes it
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take_i) |=> full_q);
  // R12: a label write restarts assembly at byte 2 next
  a_r12_label_restarts: assert property (@(posedge clk) disable iff (rst)
    cap_label |=> (cnt_q == CNT_W'(1) && !full_q));
  // R1: a low-address write with no label pending changes nothing
  a_r1_orphan_ignored: assert property (@(posedge clk) disable iff (rst)
    (cap && !label_i && cnt_q == '0) |=> (cnt_q == '0 && !full_q));
  // R11: writes while full leave the buffered word alone
  a_r11_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    (strobe && full_q && !take_i) |=> (full_q && $stable(word_o)));
endmodule

// File: rtl/arinc_word_shifter.sv
module arinc_word_shifter
  import arinc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_end_i,
  input  logic              high_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              full_i,
  input  logic              par_en_i,
  output logic              take_o,
  output logic              one_o,
  output logic              zero_o,
  output logic              nrz_o,
  output logic              sync_n_o,
  output logic              xclk_o
);
  localparam int IDX_W = $clog2(SLOT_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_XFER = IDX_W'(SLOT_BITS - 2);
  localparam logic [IDX_W-1:0] IDX_GAP0 = IDX_W'(WORD_W);
  localparam logic [IDX_W-1:0] IDX_SYNC = IDX_W'(SYNC_BIT - 1);

  logic              busy_q, queued_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              in_data;
  logic              one_q, zero_q, nrz_q, sync_n_q, xclk_q;

  assign in_data = busy_q && (idx_q < IDX_GAP0);
  assign take_o  = bit_end_i && full_i &&
                   (!busy_q || idx_q == IDX_XFER || (idx_q == IDX_LAST && !queued_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      queued_q <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
    end else if (bit_end_i) begin
      if (take_o)       sh_q <= seal_word(word_i, par_en_i);
      else if (in_data) sh_q <= sh_q >> 1;

      if (!busy_q) begin
        busy_q <= full_i;
        idx_q  <= '0;
      end else if (idx_q == IDX_LAST) begin
        queued_q <= 1'b0;
        idx_q    <= '0;
        busy_q   <= queued_q || full_i;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == IDX_XFER && full_i) queued_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      one_q    <= 1'b0;
      zero_q   <= 1'b0;
      nrz_q    <= 1'b0;
      sync_n_q <= 1'b1;
      xclk_q   <= 1'b0;
    end else begin
      xclk_q   <= high_i;
      one_q    <= in_data && high_i && sh_q[0];
      zero_q   <= in_data && high_i && !sh_q[0];
      nrz_q    <= in_data && sh_q[0];
      sync_n_q <= !(in_data && idx_q == IDX_SYNC && !high_i);
    end
  end

  assign one_o    = one_q;
  assign zero_o   = zero_q;
  assign nrz_o    = nrz_q;
  assign sync_n_o = sync_n_q;
  assign xclk_o   = xclk_q;

  a_r8_rz_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(one_q && zero_q));
  a_r8_rz_high_half: assert property (@(posedge clk) disable iff (rst)
    !xclk_q |-> !(one_q || zero_q));
  a_r10_sync_low_half: assert property (@(posedge clk) disable iff (rst)
    !sync_n_q |-> !xclk_q);
  a_r3_gap_is_null: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q >= IDX_GAP0) |=> !(one_q || zero_q || nrz_q));
  a_r6_start_after_take: assert property (@(posedge clk) disable iff (rst)
    (take_o && (!busy_q || idx_q == IDX_LAST)) |=> (busy_q && idx_q == '0));
  a_r6_take_in_gap: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!busy_q || idx_q >= IDX_XFER));
endmodule

// File: rtl/arinc_byte_tx.sv
module arinc_byte_tx
  import arinc_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] din,
  input  logic              label_wr,
  input  logic              wr_n,
  input  logic              par_en,
  output logic              ready,
  output logic              line_one,
  output logic              line_zero,
  output logic              ser_data,
  output logic              ser_sync_n,
  output logic              bit_clk
);
  logic              bit_end, high_ph, take, full;
  logic [WORD_W-1:0] word;

  arinc_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .bit_end_o(bit_end),
    .high_o   (high_ph)
  );

  arinc_byte_loader u_loader (
    .clk    (clk),
    .rst    (rst),
    .bus_i  (din),
    .label_i(label_wr),
    .wr_n_i (wr_n),
    .take_i (take),
    .word_o (word),
    .full_o (full)
  );

  arinc_word_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_end_i(bit_end),
    .high_i   (high_ph),
    .word_i   (word),
    .full_i   (full),
    .par_en_i (par_en),
    .take_o   (take),
    .one_o    (line_one),
    .zero_o   (line_zero),
    .nrz_o    (ser_data),
    .sync_n_o (ser_sync_n),
    .xclk_o   (bit_clk)
  );

  assign ready = !full;
endmodule

// File: tb/arinc_byte_tx_test.sv
module arinc_byte_tx_test;
  localparam int CPB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic       label_wr = 1'b0;
  logic       wr_n = 1'b1;
  logic       par_en = 1'b0;
  logic       ready, line_one, line_zero, ser_data, ser_sync_n, bit_clk;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  arinc_byte_tx #(.CLKS_PER_BIT(CPB)) uut (
    .clk(clk), .rst(rst), .din(din), .label_wr(label_wr), .wr_n(wr_n),
    .par_en(par_en), .ready(ready), .line_one(line_one), .line_zero(line_zero),
    .ser_data(ser_data), .ser_sync_n(ser_sync_n), .bit_clk(bit_clk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- line monitor ----------------
  logic [31:0] rx_word [0:31];
  int          rx_gap  [0:31];
  int          rx_n = 0;
  logic [31:0] acc = '0;
  int          run = 0, gapc = 0, cur_pos = 0, sync_seen = 0;
  int          cyc = 0, last_start = 0, period_len = 0;
  logic        prev_x = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_x = 1'b0; run = 0; gapc = 0; cur_pos = 0;
    end else begin
      if (bit_clk && !prev_x) begin
        period_len = cyc - last_start;
        last_start = cyc;
        chk(!(line_one && line_zero), "R8", "both markers high", {30'd0, line_one, line_zero}, 32'd0);
        if (line_one || line_zero) begin
          chk(ser_data == line_one, "R9", "nrz vs bit", {31'd0, ser_data}, {31'd0, line_one});
          acc[run] = line_one;
          run++;
          cur_pos = run;
          if (run == 32) begin
            if (rx_n < 32) begin
              rx_word[rx_n] = acc;
              rx_gap[rx_n]  = gapc;
              rx_n++;
            end
            run = 0; gapc = 0;
          end
        end else begin
          if (run != 0) chk(1'b0, "R3", "word broken by null bit", run, 32);
          if (ser_data) chk(1'b0, "R9", "nrz high in null bit", 1, 0);
          gapc++;
          cur_pos = 0;
        end
      end
      if (!bit_clk && prev_x) begin
        chk(!(line_one || line_zero), "R8", "marker in low half", {30'd0, line_one, line_zero}, 32'd0);
        chk(ser_sync_n == (cur_pos != 8), "R10", "sync in low half",
            {31'd0, ser_sync_n}, {31'd0, (cur_pos != 8)});
        if (!ser_sync_n && cur_pos == 8) sync_seen++;
      end
      if (bit_clk && !ser_sync_n) chk(1'b0, "R10", "sync low in high half", 0, 1);
      prev_x = bit_clk;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] sealed(input logic [31:0] w, input logic p);
    return p ? {~^w[30:0], w[30:0]} : w;
  endfunction

  task automatic write_byte(input logic lab, input logic [7:0] d);
    @(negedge clk);
    din = d; label_wr = lab; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_word(input logic [31:0] w);
    write_byte(1'b1, w[7:0]);
    write_byte(1'b0, w[15:8]);
    write_byte(1'b0, w[23:16]);
    write_byte(1'b0, w[31:24]);
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 3000 && rx_n < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    repeat (48) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R7", "ready after reset", ready, 1);
    chk(!line_one && !line_zero, "R7", "markers after reset", {line_one, line_zero}, 0);
    chk(ser_sync_n == 1'b1, "R7", "sync after reset", ser_sync_n, 1);
    repeat (200) @(negedge clk);
    chk(rx_n == 0, "R7", "no word before load", rx_n, 0);
  endtask

  task automatic t_orphan();
    for (int i = 0; i < 4; i++) write_byte(1'b0, 8'hC0 + 8'(i));
    chk(ready == 1'b1, "R1", "ready after orphan low writes", ready, 1);
    repeat (100) @(negedge clk);
    chk(rx_n == 0, "R1", "orphan writes sent nothing", rx_n, 0);
  endtask

  task automatic t_single();
    int base, lat;
    base = rx_n; par_en = 1'b0;
    load_word(32'hA5C3_0F81);
    chk(ready == 1'b0, "R5", "ready low after byte 4", ready, 0);
    lat = 0;
    while (!ready && lat < 3 * CPB) begin @(negedge clk); lat++; end
    chk(lat <= CPB + 1, "R6", "idle transfer latency", lat, CPB + 1);
    wait_words(base + 1);
    chk(rx_n == base + 1, "R2", "word count", rx_n, base + 1);
    chk(rx_word[base] == 32'hA5C3_0F81, "R2", "byte order", rx_word[base], 32'hA5C3_0F81);
    chk(rx_word[base][31] == 1'b1, "R4", "bit 32 is D7 with parity off", rx_word[base][31], 1);
    chk(period_len == CPB, "R3", "bit period length", period_len, CPB);
  endtask

  task automatic t_back_to_back();
    int base;
    settle();
    base = rx_n;
    load_word(32'h1234_5678);
    while (!ready) @(negedge clk);
    load_word(32'h8765_4321);
    chk(ready == 1'b0, "R5", "ready low with word waiting", ready, 0);
    repeat (40) @(negedge clk);
    chk(ready == 1'b0, "R6", "no transfer before gap", ready, 0);
    wait_words(base + 2);
    chk(rx_word[base] == 32'h1234_5678, "R2", "first word", rx_word[base], 32'h1234_5678);
    chk(rx_word[base + 1] == 32'h8765_4321, "R2", "second word", rx_word[base + 1], 32'h8765_4321);
    chk(rx_gap[base + 1] == 4, "R3", "gap between words", rx_gap[base + 1], 4);
    chk(ready == 1'b1, "R5", "ready after transfer", ready, 1);
  endtask

  task automatic t_parity();
    int base;
    settle();
    base = rx_n; par_en = 1'b1;
    load_word(32'h0000_0003);
    while (!ready) @(negedge clk);
    load_word(32'h8000_0007);
    wait_words(base + 2);
    chk(rx_word[base] == sealed(32'h0000_0003, 1'b1), "R4", "parity even body",
        rx_word[base], sealed(32'h0000_0003, 1'b1));
    chk(rx_word[base + 1] == sealed(32'h8000_0007, 1'b1), "R4", "parity odd body",
        rx_word[base + 1], sealed(32'h8000_0007, 1'b1));
    chk(^rx_word[base + 1] == 1'b1, "R4", "odd count of ones", ^rx_word[base + 1], 1);
    par_en = 1'b0;
  endtask

  task automatic t_ignored();
    int base;
    settle();
    base = rx_n;
    load_word(32'h0F0F_F0F0);
    while (!ready) @(negedge clk);
    load_word(32'h3C3C_A5A5);
    chk(ready == 1'b0, "R11", "ready low before junk", ready, 0);
    write_byte(1'b1, 8'hFF);
    write_byte(1'b0, 8'h00);
    write_byte(1'b0, 8'h00);
    write_byte(1'b0, 8'h00);
    wait_words(base + 2);
    chk(rx_word[base + 1] == 32'h3C3C_A5A5, "R11", "writes while busy ignored",
        rx_word[base + 1], 32'h3C3C_A5A5);
    chk(rx_gap[base + 1] == 4, "R6", "queued word after 4 gap bits", rx_gap[base + 1], 4);
  endtask

  task automatic t_restart();
    int base;
    settle();
    base = rx_n;
    write_byte(1'b1, 8'h11);
    write_byte(1'b0, 8'h22);
    write_byte(1'b1, 8'h5A);
    chk(ready == 1'b1, "R12", "ready during restarted word", ready, 1);
    write_byte(1'b0, 8'h33);
    write_byte(1'b0, 8'h44);
    write_byte(1'b0, 8'h66);
    wait_words(base + 1);
    chk(rx_word[base] == 32'h6644_335A, "R12", "partial word discarded",
        rx_word[base], 32'h6644_335A);
    chk(rx_gap[base] > 4, "R6", "idle start after long null", rx_gap[base], 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_orphan();
    t_single();
    t_back_to_back();
    t_parity();
    t_ignored();
    t_restart();
    settle();
    chk(sync_seen == rx_n, "R10", "one sync pulse per word", sync_seen, rx_n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule